// File: doc/BRIEF.md
# Chip-Select Window Decoder

This block sits between the address source of an external bus port and the bus sequencer. For each external access it chooses one of up to five chip-select lines and trims the address to the number of external address lines in use. It also passes along the bus-mode code that the sequencer needs for the selected device. Chip selects 1 to 4 each own a programmable window, set by a base address, a power-of-two size and a mode code. Chip select 0 has no window. It takes every access that no enabled window claims, and its mode code comes from strap pins.

Three strap fields are captured while reset is held, and the values present at the last clock edge of reset are kept: the external address width, the number of chip selects that are active, and the mode of chip select 0. Later changes on those pins have no effect until the next reset. Software writes window settings through a one-cycle write strobe. An oversized window is clamped to the strapped space and raises a sticky error flag. Two enabled windows that both claim the same access raise a sticky overlap flag.

Accesses enter on a valid/ready request channel and leave on a valid/ready response channel, with one register stage between them. The request side is ready whenever the response register is empty or is being drained in the same cycle. A stalled response holds all of its fields unchanged until it is taken. Strobe timing is handled elsewhere.

Top module: `cs_window_decoder`

## Requirements
- R1: After reset, `rsp_valid`, `ovl_flag` and `cfg_err` are 0, `req_ready` is 1, and all windows are disabled, so every access selects chip select 0.
- R2: The address-size strap decodes as 01 = 16 lines, 11 = 18 lines, 00 = 20 lines, 10 = 24 lines. `rsp_addr` is `req_addr` with every bit at or above the line count forced to 0.
- R3: The strap fields are captured on each clock edge while `rst_n` is low. Changes on the strap pins after reset has been released do not affect masking, the active count or the chip select 0 mode.
- R4: Window i (chip select i+1) with size code k covers 2^(12+k) bytes. It claims a masked address when it is enabled and that address agrees with its base in every bit from position 12+k upward.
- R5: An access that no active, enabled window claims drives `rsp_cs` = 5'b00001, and `rsp_mode` equals the chip select 0 strap.
- R6: An access claimed by window i drives `rsp_cs` bit i+1 alone, and `rsp_mode` equals that window's configured mode.
- R7: When two or more windows claim an access, the lowest-numbered one wins. `ovl_flag` then rises and stays at 1 until reset.
- R8: A write whose size code exceeds (line count - 12) stores that maximum code instead and sets `cfg_err`, which stays at 1 until reset.
- R9: Given a strapped active count n (1 to 5), chip selects n and above are never asserted, and accesses in their windows fall through to chip select 0.
- R10: `req_ready` = !`rsp_valid` || `rsp_ready`. A response appears on the cycle after its request is accepted. While `rsp_valid` is 1 and `rsp_ready` is 0, every response field stays unchanged.
- R11: Whenever `rsp_valid` is 1, exactly one bit of `rsp_cs` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; straps are captured while it is low |
| strap_addr_size | input | 2 | Address-line count strap |
| strap_cs_count | input | 3 | Number of active chip selects (1 to 5) |
| strap_cs0_mode | input | 2 | Bus mode for chip select 0 |
| cfg_we | input | 1 | Window configuration write strobe |
| cfg_sel | input | 2 | Window index (0 = chip select 1) |
| cfg_en | input | 1 | Window enable |
| cfg_base | input | 24 | Window base address |
| cfg_size | input | 4 | Size code k, window = 2^(12+k) bytes |
| cfg_mode | input | 2 | Window bus mode |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request ready |
| req_addr | input | 24 | Access address |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response ready |
| rsp_cs | output | 5 | One-hot chip select |
| rsp_addr | output | 24 | Masked address |
| rsp_mode | output | 2 | Bus mode of selected device |
| ovl_flag | output | 1 | Sticky window overlap flag |
| cfg_err | output | 1 | Sticky oversize configuration flag |

## Verification
Addresses are placed inside a large window, inside a 4 KB window, exactly on its upper edge, just outside it, and in unmapped space. These placements show whether the boundary bit index is right and whether unmatched space falls back to chip select 0. One address lies where two windows overlap, which checks both the priority order and the sticky flag. High-bit addresses run under three different address-size straps, which separates the masking widths and shows that strap changes after reset are ignored. A window beyond the active count, an oversized write whose clamping changes the result, and a stalled response followed by a queued request cover the gating, clamping and back-pressure rules.

// File: rtl/csw_pkg.sv
package csw_pkg;
  localparam int unsigned CSW_ADDR_W = 24;
  localparam int unsigned CSW_NUM_WIN = 4;
  localparam int unsigned CSW_PAGE_LOG2 = 12;
  localparam int unsigned CSW_SIZE_W = 4;
  localparam int unsigned CSW_MODE_W = 2;
  localparam int unsigned CSW_CNT_W = 3;

  // address-size strap codes
  typedef enum logic [1:0] {
    ASZ_20 = 2'b00,
    ASZ_16 = 2'b01,
    ASZ_24 = 2'b10,
    ASZ_18 = 2'b11
  } addr_size_e;
endpackage

// File: rtl/csw_strap_latch.sv
module csw_strap_latch
  import csw_pkg::*;
#(
  parameter int unsigned ADDR_W = CSW_ADDR_W,
  parameter int unsigned NUM_WIN = CSW_NUM_WIN,
  parameter int unsigned PAGE_LOG2 = CSW_PAGE_LOG2,
  parameter int unsigned SIZE_W = CSW_SIZE_W,
  parameter int unsigned MODE_W = CSW_MODE_W,
  parameter int unsigned CNT_W = CSW_CNT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        strap_addr_size,
  input  logic [CNT_W-1:0]  strap_cs_count,
  input  logic [MODE_W-1:0] strap_cs0_mode,
  output logic [ADDR_W-1:0] addr_mask,
  output logic [SIZE_W-1:0] max_size,
  output logic [CNT_W-1:0]  active_cnt,
  output logic [MODE_W-1:0] cs0_mode
);
  localparam int unsigned NUM_CS = NUM_WIN + 1;
  localparam int unsigned LINE_W = $clog2(ADDR_W + 1) + 1;

  addr_size_e        size_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [MODE_W-1:0] mode_q;
  logic [LINE_W-1:0] lines;

  // capture while reset is held; last edge before release wins
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      size_q <= addr_size_e'(strap_addr_size);
      cnt_q  <= strap_cs_count;
      mode_q <= strap_cs0_mode;
    end
  end

  always_comb begin
    case (size_q)
      ASZ_16:  lines = LINE_W'(16);
      ASZ_18:  lines = LINE_W'(18);
      ASZ_20:  lines = LINE_W'(20);
      default: lines = LINE_W'(24);
    endcase
    if (lines > LINE_W'(ADDR_W)) lines = LINE_W'(ADDR_W);
  end

  for (genvar b = 0; b < ADDR_W; b++) begin : g_mask
    assign addr_mask[b] = (LINE_W'(b) < lines);
  end

  assign max_size = SIZE_W'(lines - LINE_W'(PAGE_LOG2));

  always_comb begin
    if (cnt_q == '0) active_cnt = CNT_W'(1);
    else if (cnt_q > CNT_W'(NUM_CS)) active_cnt = CNT_W'(NUM_CS);
    else active_cnt = cnt_q;
  end

  assign cs0_mode = mode_q;
endmodule

// File: rtl/csw_win_bank.sv
module csw_win_bank
  import csw_pkg::*;
#(
  parameter int unsigned ADDR_W = CSW_ADDR_W,
  parameter int unsigned NUM_WIN = CSW_NUM_WIN,
  parameter int unsigned SIZE_W = CSW_SIZE_W,
  parameter int unsigned MODE_W = CSW_MODE_W,
  localparam int unsigned SEL_W = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            cfg_we,
  input  logic [SEL_W-1:0]                cfg_sel,
  input  logic                            cfg_en,
  input  logic [ADDR_W-1:0]               cfg_base,
  input  logic [SIZE_W-1:0]               cfg_size,
  input  logic [MODE_W-1:0]               cfg_mode,
  input  logic [SIZE_W-1:0]               max_size,
  output logic [NUM_WIN-1:0]              win_en,
  output logic [NUM_WIN-1:0][ADDR_W-1:0]  win_base,
  output logic [NUM_WIN-1:0][SIZE_W-1:0]  win_size,
  output logic [NUM_WIN-1:0][MODE_W-1:0]  win_mode,
  output logic                            cfg_err
);
  logic              too_big;
  logic [SIZE_W-1:0] size_eff;

  assign too_big  = (cfg_size > max_size);
  assign size_eff = too_big ? max_size : cfg_size;

  for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        win_en[i]   <= 1'b0;
        win_base[i] <= '0;
        win_size[i] <= '0;
        win_mode[i] <= '0;
      end else if (cfg_we && (cfg_sel == SEL_W'(i))) begin
        win_en[i]   <= cfg_en;
        win_base[i] <= cfg_base;
        win_size[i] <= size_eff;
        win_mode[i] <= cfg_mode;
      end
    end

    // R8
    size_in_space_chk: assert property (@(posedge clk) disable iff (!rst_n)
      win_en[i] |-> (win_size[i] <= max_size));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cfg_err <= 1'b0;
    else if (cfg_we && too_big) cfg_err <= 1'b1;
  end

  // R8
  cfg_err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> cfg_err);
endmodule

// File: rtl/csw_win_match.sv
module csw_win_match
  import csw_pkg::*;
#(
  parameter int unsigned ADDR_W = CSW_ADDR_W,
  parameter int unsigned NUM_WIN = CSW_NUM_WIN,
  parameter int unsigned PAGE_LOG2 = CSW_PAGE_LOG2,
  parameter int unsigned SIZE_W = CSW_SIZE_W,
  parameter int unsigned CNT_W = CSW_CNT_W
) (
  input  logic [ADDR_W-1:0]               addr,
  input  logic [CNT_W-1:0]                active_cnt,
  input  logic [NUM_WIN-1:0]              win_en,
  input  logic [NUM_WIN-1:0][ADDR_W-1:0]  win_base,
  input  logic [NUM_WIN-1:0][SIZE_W-1:0]  win_size,
  output logic [NUM_WIN-1:0]              hit
);
  localparam int unsigned POS_W = $clog2(ADDR_W + (1 << SIZE_W) + PAGE_LOG2) + 1;

  function automatic logic [ADDR_W-1:0] upper_mask(input logic [SIZE_W-1:0] k);
    logic [POS_W-1:0] edge_pos;
    edge_pos = POS_W'(PAGE_LOG2) + POS_W'(k);
    for (int b = 0; b < ADDR_W; b++) upper_mask[b] = (POS_W'(b) >= edge_pos);
  endfunction

  for (genvar i = 0; i < NUM_WIN; i++) begin : g_hit
    logic live;
    assign live   = win_en[i] && (CNT_W'(i + 1) < active_cnt);
    assign hit[i] = live && (((addr ^ win_base[i]) & upper_mask(win_size[i])) == '0);
  end
endmodule

// File: rtl/cs_window_decoder.sv
module cs_window_decoder
  import csw_pkg::*;
#(
  parameter int unsigned ADDR_W = CSW_ADDR_W,
  parameter int unsigned NUM_WIN = CSW_NUM_WIN,
  parameter int unsigned PAGE_LOG2 = CSW_PAGE_LOG2,
  parameter int unsigned SIZE_W = CSW_SIZE_W,
  parameter int unsigned MODE_W = CSW_MODE_W,
  parameter int unsigned CNT_W = CSW_CNT_W,
  localparam int unsigned NUM_CS = NUM_WIN + 1,
  localparam int unsigned SEL_W = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        strap_addr_size,
  input  logic [CNT_W-1:0]  strap_cs_count,
  input  logic [MODE_W-1:0] strap_cs0_mode,
  input  logic              cfg_we,
  input  logic [SEL_W-1:0]  cfg_sel,
  input  logic              cfg_en,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [SIZE_W-1:0] cfg_size,
  input  logic [MODE_W-1:0] cfg_mode,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [NUM_CS-1:0] rsp_cs,
  output logic [ADDR_W-1:0] rsp_addr,
  output logic [MODE_W-1:0] rsp_mode,
  output logic              ovl_flag,
  output logic              cfg_err
);
  logic [ADDR_W-1:0]              addr_mask;
  logic [SIZE_W-1:0]              max_size;
  logic [CNT_W-1:0]               active_cnt;
  logic [MODE_W-1:0]              cs0_mode;
  logic [NUM_WIN-1:0]             win_en;
  logic [NUM_WIN-1:0][ADDR_W-1:0] win_base;
  logic [NUM_WIN-1:0][SIZE_W-1:0] win_size;
  logic [NUM_WIN-1:0][MODE_W-1:0] win_mode;
  logic [NUM_WIN-1:0]             hit;
  logic [ADDR_W-1:0]              addr_m;
  logic [NUM_CS-1:0]              cs_nxt;
  logic [MODE_W-1:0]              mode_nxt;
  logic                           multi_hit;
  logic                           accept;

  csw_strap_latch #(
    .ADDR_W(ADDR_W), .NUM_WIN(NUM_WIN), .PAGE_LOG2(PAGE_LOG2),
    .SIZE_W(SIZE_W), .MODE_W(MODE_W), .CNT_W(CNT_W)
  ) u_strap (
    .clk(clk), .rst_n(rst_n),
    .strap_addr_size(strap_addr_size), .strap_cs_count(strap_cs_count),
    .strap_cs0_mode(strap_cs0_mode),
    .addr_mask(addr_mask), .max_size(max_size),
    .active_cnt(active_cnt), .cs0_mode(cs0_mode)
  );

  csw_win_bank #(
    .ADDR_W(ADDR_W), .NUM_WIN(NUM_WIN), .SIZE_W(SIZE_W), .MODE_W(MODE_W)
  ) u_bank (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_en(cfg_en), .cfg_base(cfg_base),
    .cfg_size(cfg_size), .cfg_mode(cfg_mode), .max_size(max_size),
    .win_en(win_en), .win_base(win_base), .win_size(win_size),
    .win_mode(win_mode), .cfg_err(cfg_err)
  );

  assign addr_m = req_addr & addr_mask;

  csw_win_match #(
    .ADDR_W(ADDR_W), .NUM_WIN(NUM_WIN), .PAGE_LOG2(PAGE_LOG2),
    .SIZE_W(SIZE_W), .CNT_W(CNT_W)
  ) u_match (
    .addr(addr_m), .active_cnt(active_cnt), .win_en(win_en),
    .win_base(win_base), .win_size(win_size), .hit(hit)
  );

  // lowest-numbered claiming window wins; scan from the top down
  always_comb begin
    cs_nxt   = NUM_CS'(1);
    mode_nxt = cs0_mode;
    for (int i = NUM_WIN - 1; i >= 0; i--) begin
      if (hit[i]) begin
        cs_nxt   = NUM_CS'(1) << (i + 1);
        mode_nxt = win_mode[i];
      end
    end
  end

  always_comb begin
    int n;
    n = 0;
    for (int i = 0; i < NUM_WIN; i++) n += int'(hit[i]);
    multi_hit = (n > 1);
  end

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_cs    <= NUM_CS'(1);
      rsp_addr  <= '0;
      rsp_mode  <= '0;
      ovl_flag  <= 1'b0;
    end else begin
      if (accept) begin
        rsp_valid <= 1'b1;
        rsp_cs    <= cs_nxt;
        rsp_addr  <= addr_m;
        rsp_mode  <= mode_nxt;
      end else if (rsp_ready) begin
        rsp_valid <= 1'b0;
      end
      if (accept && multi_hit) ovl_flag <= 1'b1;
    end
  end

  // R11
  cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($countones(rsp_cs) == 1));

  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_cs)
      && $stable(rsp_addr) && $stable(rsp_mode)));

  // R7
  ovl_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovl_flag |=> ovl_flag);

  // R2
  addr_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ((rsp_addr & ~addr_mask) == '0));

  // R9
  inactive_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ((rsp_cs >> active_cnt) == '0));
endmodule

// File: tb/cs_window_decoder_test.sv
module cs_window_decoder_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  strap_addr_size = 2'b10;
  logic [2:0]  strap_cs_count = 3'd5;
  logic [1:0]  strap_cs0_mode = 2'd3;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic        cfg_en = 1'b0;
  logic [23:0] cfg_base = '0;
  logic [3:0]  cfg_size = '0;
  logic [1:0]  cfg_mode = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [23:0] req_addr = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [4:0]  rsp_cs;
  logic [23:0] rsp_addr;
  logic [1:0]  rsp_mode;
  logic        ovl_flag;
  logic        cfg_err;

  int checks = 0;
  int fails = 0;

  always #2 clk = ~clk;

  cs_window_decoder uut (
    .clk(clk), .rst_n(rst_n),
    .strap_addr_size(strap_addr_size), .strap_cs_count(strap_cs_count),
    .strap_cs0_mode(strap_cs0_mode),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_en(cfg_en), .cfg_base(cfg_base),
    .cfg_size(cfg_size), .cfg_mode(cfg_mode),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_cs(rsp_cs),
    .rsp_addr(rsp_addr), .rsp_mode(rsp_mode),
    .ovl_flag(ovl_flag), .cfg_err(cfg_err)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic [1:0] sz, input logic [2:0] cnt, input logic [1:0] md);
    @(negedge clk);
    rst_n = 1'b0;
    strap_addr_size = sz;
    strap_cs_count = cnt;
    strap_cs0_mode = md;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic write_win(input logic [1:0] idx, input logic en, input logic [23:0] base,
                           input logic [3:0] k, input logic [1:0] md);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = idx; cfg_en = en; cfg_base = base; cfg_size = k; cfg_mode = md;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic access(input string tag, input logic [23:0] a, input logic [4:0] ecs,
                        input logic [23:0] eaddr, input logic [1:0] emode);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    check({tag, " valid"}, 32'(rsp_valid), 32'd1);
    check({tag, " cs"}, 32'(rsp_cs), 32'(ecs));
    check({tag, " addr"}, 32'(rsp_addr), 32'(eaddr));
    check({tag, " mode"}, 32'(rsp_mode), 32'(emode));
  endtask

  task automatic t_reset_fallback();
    do_reset(2'b10, 3'd5, 2'd3);
    @(negedge clk);
    check("R1 rsp_valid", 32'(rsp_valid), 32'd0);
    check("R1 req_ready", 32'(req_ready), 32'd1);
    check("R1 ovl_flag", 32'(ovl_flag), 32'd0);
    check("R1 cfg_err", 32'(cfg_err), 32'd0);
    access("R1 R5 default cs0", 24'h123456, 5'b00001, 24'h123456, 2'd3);
  endtask

  task automatic t_windows();
    write_win(2'd0, 1'b1, 24'h100000, 4'd8, 2'd1);  // 1 MB
    write_win(2'd1, 1'b1, 24'h200000, 4'd0, 2'd2);  // 4 KB
    access("R4 R6 cs1 inside", 24'h1ABCDE, 5'b00010, 24'h1ABCDE, 2'd1);
    access("R4 R6 cs2 top byte", 24'h200FFF, 5'b00100, 24'h200FFF, 2'd2);
    access("R4 R5 just past cs2", 24'h201000, 5'b00001, 24'h201000, 2'd3);
    access("R4 R5 below cs1", 24'h0FFFFF, 5'b00001, 24'h0FFFFF, 2'd3);
  endtask

  task automatic t_overlap();
    write_win(2'd2, 1'b1, 24'h180000, 4'd4, 2'd3);  // 64 KB inside cs1
    check("R7 ovl before", 32'(ovl_flag), 32'd0);
    access("R7 overlap priority", 24'h185000, 5'b00010, 24'h185000, 2'd1);
    check("R7 ovl set", 32'(ovl_flag), 32'd1);
    access("R7 later access", 24'h200010, 5'b00100, 24'h200010, 2'd2);
    check("R7 ovl sticky", 32'(ovl_flag), 32'd1);
  endtask

  task automatic t_backpressure();
    @(negedge clk);
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_addr = 24'h1ABCDE;
    @(negedge clk);
    req_addr = 24'h000010;
    check("R10 first rsp valid", 32'(rsp_valid), 32'd1);
    check("R10 ready low stalled", 32'(req_ready), 32'd0);
    check("R10 first cs", 32'(rsp_cs), 32'b00010);
    @(negedge clk);
    check("R10 held cs", 32'(rsp_cs), 32'b00010);
    check("R10 held addr", 32'(rsp_addr), 32'h1ABCDE);
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check("R10 second valid", 32'(rsp_valid), 32'd1);
    check("R10 second cs", 32'(rsp_cs), 32'b00001);
    check("R10 second addr", 32'(rsp_addr), 32'h000010);
    @(negedge clk);
    check("R10 drained", 32'(rsp_valid), 32'd0);
  endtask

  task automatic t_clamp_mask();
    do_reset(2'b01, 3'd5, 2'd1);  // 16 lines
    @(negedge clk);
    check("R1 ovl cleared", 32'(ovl_flag), 32'd0);
    strap_addr_size = 2'b10;      // after reset: must be ignored
    strap_cs0_mode = 2'd2;
    access("R2 R3 16-line mask", 24'hAB3456, 5'b00001, 24'h003456, 2'd1);
    write_win(2'd0, 1'b1, 24'h010000, 4'd8, 2'd2);
    check("R8 cfg_err set", 32'(cfg_err), 32'd1);
    // clamped to 64 KB: base bit 16 now compared, so no claim
    access("R8 clamped window", 24'h003456, 5'b00001, 24'h003456, 2'd1);
    write_win(2'd1, 1'b1, 24'h000000, 4'd2, 2'd3);
    check("R8 cfg_err sticky", 32'(cfg_err), 32'd1);
    access("R6 cs2 in 16-line", 24'hFF0100, 5'b00100, 24'h000100, 2'd3);
  endtask

  task automatic t_active_count();
    do_reset(2'b11, 3'd2, 2'd0);  // 18 lines, cs0 and cs1 live
    @(negedge clk);
    check("R1 cfg_err cleared", 32'(cfg_err), 32'd0);
    access("R2 18-line mask", 24'hFFFFFF, 5'b00001, 24'h03FFFF, 2'd0);
    write_win(2'd1, 1'b1, 24'h020000, 4'd4, 2'd2);
    access("R9 inactive cs2", 24'h020010, 5'b00001, 24'h020010, 2'd0);
    write_win(2'd0, 1'b1, 24'h000000, 4'd4, 2'd1);
    access("R9 active cs1", 24'h000010, 5'b00010, 24'h000010, 2'd1);
    strap_cs_count = 3'd5;
    access("R3 count held", 24'h020020, 5'b00001, 24'h020020, 2'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    t_reset_fallback();
    t_windows();
    t_overlap();
    t_backpressure();
    t_clamp_mask();
    t_active_count();
    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule